// File: doc/BRIEF.md
# Three-wire wiper position controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. A host drives three slow control lines: an active-low chip select, an active-low increment strobe and an up/down direction line. While the block is selected, each high-to-low transition of the increment line moves a 5-bit wiper position one tap up or down. The position stops at both ends of the array and never wraps.

The position is decoded into a one-hot tap-select vector that drives the analog switch array, which is outside this block. Reset stands in for power-up and loads the mid-scale tap 15. All three control lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and increment edges are detected on the synchronized samples. The block also gives a one-clock pulse for each tap change. It raises a standby flag when chip select is released while the increment line is high, and clears that flag when the block is selected again.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset, `position_o` is 15, `tap_sel_o` has only bit 15 set, and `standby_o` and `moved_o` are 0.
- R2: While `sel_n_i` is 0, a 1-to-0 transition of `inc_n_i` raises `position_o` by one when `dir_up_i` is 1 and lowers it by one when `dir_up_i` is 0. The new value appears on the third rising clock edge after the input falls.
- R3: An up step at position 31 and a down step at position 0 leave the position unchanged and produce no `moved_o` pulse. The position never wraps.
- R4: While `sel_n_i` is 1, transitions of `inc_n_i` do not change the position.
- R5: A falling `inc_n_i` edge that reaches the synchronizer outputs in the same cycle as a rising `sel_n_i` is ignored.
- R6: `tap_sel_o` always has exactly one bit set, and that bit's index equals `position_o` (bit 0 is the low end).
- R7: `moved_o` is 1 for exactly one clock, in the first cycle in which `position_o` shows a new value. It is 1 at no other time.
- R8: When `sel_n_i` rises while `inc_n_i` is 1, `standby_o` becomes 1 and the position is held. `standby_o` returns to 0 once `sel_n_i` is 0 again.
- R9: When `sel_n_i` rises while `inc_n_i` is 0, `standby_o` stays 0.
- R10: `dir_up_i` may change while `sel_n_i` stays 0. Each later step follows the new direction within the same selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sel_n_i | input | 1 | Active-low chip select, asynchronous |
| inc_n_i | input | 1 | Increment strobe; a falling edge steps the wiper, asynchronous |
| dir_up_i | input | 1 | Step direction: 1 moves up, 0 moves down, asynchronous |
| tap_sel_o | output | 32 | One-hot tap select |
| position_o | output | 5 | Current wiper position |
| moved_o | output | 1 | One-clock pulse when the position changes |
| standby_o | output | 1 | Standby flag |

## Verification
The bench drives the wiper into both end stops and keeps stepping. A counter that wraps would jump between 0 and 31, and one that reports refused steps would pulse `moved_o`. The bench also releases chip select with the increment line high and with it low, and it lowers increment in the same cycle that chip select rises. A design that sets standby on any deselect, or that acts on the edge while chip select rises, would show a wrong flag or a stray step. Steps made while deselected and direction changes within one selection catch a design that ignores chip select or latches the direction only once.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_e;

    typedef struct packed {
        logic sel_n;
        logic inc_n;
        logic up;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RESET_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/wiper_edge_ctrl.sv
module wiper_edge_ctrl
    import wiper_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctl_t  ctl_i,
    output move_e move_o,
    output logic  standby_o
);

    typedef struct packed {
        logic inc_prev_n;
        logic sel_prev_n;
        logic standby;
    } edge_state_t;

    edge_state_t st_d, st_q;
    move_e       move_d;
    logic        inc_fall;
    logic        sel_rise;

    always_comb begin
        st_d       = st_q;
        move_d     = MOVE_HOLD;
        inc_fall   = st_q.inc_prev_n & ~ctl_i.inc_n;
        sel_rise   = ~st_q.sel_prev_n & ctl_i.sel_n;

        st_d.inc_prev_n = ctl_i.inc_n;
        st_d.sel_prev_n = ctl_i.sel_n;

        // accept a step only while the synchronized select is low
        if (inc_fall && !ctl_i.sel_n) begin
            move_d = ctl_i.up ? MOVE_UP : MOVE_DOWN;
        end

        if (!ctl_i.sel_n) begin
            st_d.standby = 1'b0;
        end else if (sel_rise && ctl_i.inc_n) begin
            st_d.standby = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.inc_prev_n <= 1'b1;
            st_q.sel_prev_n <= 1'b1;
            st_q.standby    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign move_o    = move_d;
    assign standby_o = st_q.standby;

endmodule

// File: rtl/wiper_pos_counter.sv
module wiper_pos_counter
    import wiper_pkg::*;
#(
    parameter int TAP_COUNT   = 32,
    parameter int DEFAULT_TAP = 15,
    localparam int POS_W      = $clog2(TAP_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  move_e            move_i,
    output logic [POS_W-1:0] pos_o,
    output logic             moved_o
);

    localparam logic [POS_W-1:0] POS_MAX  = POS_W'(TAP_COUNT - 1);
    localparam logic [POS_W-1:0] POS_INIT = POS_W'(DEFAULT_TAP);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             moved;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d       = cnt_q;
        cnt_d.moved = 1'b0;
        unique case (move_i)
            MOVE_UP: begin
                if (cnt_q.pos != POS_MAX) begin
                    cnt_d.pos   = cnt_q.pos + POS_W'(1);
                    cnt_d.moved = 1'b1;
                end
            end
            MOVE_DOWN: begin
                if (cnt_q.pos != '0) begin
                    cnt_d.pos   = cnt_q.pos - POS_W'(1);
                    cnt_d.moved = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.pos   <= POS_INIT;
            cnt_q.moved <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pos_o   = cnt_q.pos;
    assign moved_o = cnt_q.moved;

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int TAP_COUNT = 32,
    localparam int POS_W    = $clog2(TAP_COUNT)
) (
    input  logic [POS_W-1:0]     pos_i,
    output logic [TAP_COUNT-1:0] tap_sel_o
);

    for (genvar i = 0; i < TAP_COUNT; i++) begin : g_tap
        assign tap_sel_o[i] = (pos_i == POS_W'(i));
    end

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wiper_pkg::*;
#(
    parameter int TAP_COUNT   = 32,
    parameter int DEFAULT_TAP = 15,
    parameter int SYNC_STAGES = 2,
    localparam int POS_W      = $clog2(TAP_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n_i,
    input  logic                 inc_n_i,
    input  logic                 dir_up_i,
    output logic [TAP_COUNT-1:0] tap_sel_o,
    output logic [POS_W-1:0]     position_o,
    output logic                 moved_o,
    output logic                 standby_o
);

    // idle lines: deselected, increment high, direction don't-care
    localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'(3'b110);

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_sync;
    ctl_t             ctl;
    move_e            move;

    assign ctl_raw = {sel_n_i, inc_n_i, dir_up_i};
    assign ctl     = ctl_t'(ctl_sync);

    wiper_sync #(
        .WIDTH     (CTL_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CTL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_sync)
    );

    wiper_edge_ctrl u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl),
        .move_o    (move),
        .standby_o (standby_o)
    );

    wiper_pos_counter #(
        .TAP_COUNT   (TAP_COUNT),
        .DEFAULT_TAP (DEFAULT_TAP)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .move_i  (move),
        .pos_o   (position_o),
        .moved_o (moved_o)
    );

    wiper_tap_decode #(
        .TAP_COUNT (TAP_COUNT)
    ) u_dec (
        .pos_i     (position_o),
        .tap_sel_o (tap_sel_o)
    );

endmodule

// File: rtl/wiper_step_ctrl_chk.sv
module wiper_step_ctrl_chk #(
    parameter int TAP_COUNT = 32,
    localparam int POS_W    = $clog2(TAP_COUNT)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TAP_COUNT-1:0] tap_sel_o,
    input logic [POS_W-1:0]     position_o,
    input logic                 moved_o,
    input logic                 standby_o
);

    localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAP_COUNT - 1);

    assert_tap_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel_o) == 1) && tap_sel_o[position_o]);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, position_o} == {1'b0, $past(position_o)}) ||
        ({1'b0, position_o} == {1'b0, $past(position_o)} + 1'b1) ||
        ({1'b0, position_o} + 1'b1 == {1'b0, $past(position_o)}));

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(position_o) == POS_MAX) |-> (position_o != '0));

    assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(position_o) == '0) |-> (position_o != POS_MAX));

    assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        moved_o |-> !$stable(position_o));

    assert_change_has_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(position_o) |-> moved_o);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        moved_o |=> !moved_o);

    assert_standby_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> $stable(position_o));

endmodule

bind wiper_step_ctrl wiper_step_ctrl_chk #(
    .TAP_COUNT (TAP_COUNT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_sel_o  (tap_sel_o),
    .position_o (position_o),
    .moved_o    (moved_o),
    .standby_o  (standby_o)
);

// File: tb/tb_wiper_step_ctrl.sv
`timescale 1ns/1ps
module tb_wiper_step_ctrl;

    localparam int TAPS  = 32;
    localparam int PW    = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel_n = 1'b1;
    logic            inc_n = 1'b1;
    logic            dir_up = 1'b0;
    logic [TAPS-1:0] tap_sel;
    logic [PW-1:0]   position;
    logic            moved;
    logic            standby;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    int model_pos = 15;
    bit moved_prev = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wiper_step_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_i    (sel_n),
        .inc_n_i    (inc_n),
        .dir_up_i   (dir_up),
        .tap_sel_o  (tap_sel),
        .position_o (position),
        .moved_o    (moved),
        .standby_o  (standby)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one increment pulse; pushes the expected position when the model moves
    task automatic step_once(input bit selected);
        int nxt;
        nxt = model_pos;
        if (selected) begin
            if (dir_up && model_pos < TAPS - 1) nxt = model_pos + 1;
            if (!dir_up && model_pos > 0)       nxt = model_pos - 1;
        end
        if (nxt != model_pos) exp_q.push_back(nxt);
        model_pos = nxt;
        @(negedge clk) inc_n = 1'b0;
        idle(4);
        inc_n = 1'b1;
        idle(4);
    endtask

    // monitor: each moved pulse must match the next expected position (R2, R6, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (moved) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected pulse", int'(position), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(position) == e, "R2 step position", int'(position), e);
                    check(tap_sel == (TAPS'(1) << e), "R6 tap select", int'(tap_sel), e);
                end
                check(!moved_prev, "R7 pulse width", 2, 1);
            end
            moved_prev = moved;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        check(position == 15, "R1 reset position", int'(position), 15);
        check(tap_sel == (TAPS'(1) << 15), "R1 reset tap select", int'(tap_sel), 32768);
        check(standby == 1'b0, "R1 reset standby", int'(standby), 0);
        check(moved == 1'b0, "R1 reset moved", int'(moved), 0);

        // select, step up three times, then down twice in the same selection (R2, R10)
        sel_n = 1'b0;
        idle(4);
        dir_up = 1'b1;
        repeat (3) step_once(1'b1);
        check(position == 18, "R2 up steps", int'(position), 18);
        dir_up = 1'b0;
        repeat (2) step_once(1'b1);
        check(position == 16, "R10 direction change", int'(position), 16);

        // top end stop (R3)
        dir_up = 1'b1;
        repeat (17) step_once(1'b1);
        check(position == 31, "R3 top saturation", int'(position), 31);
        check(tap_sel == (TAPS'(1) << 31), "R6 top tap", int'(tap_sel[31]), 1);

        // bottom end stop (R3)
        dir_up = 1'b0;
        repeat (33) step_once(1'b1);
        check(position == 0, "R3 bottom saturation", int'(position), 0);
        check(tap_sel == TAPS'(1), "R6 bottom tap", int'(tap_sel), 1);

        // deselect with increment high: standby (R8)
        sel_n = 1'b1;
        idle(5);
        check(standby == 1'b1, "R8 standby set", int'(standby), 1);
        // increment while deselected has no effect (R4)
        dir_up = 1'b1;
        step_once(1'b0);
        check(position == 0, "R4 deselected step", int'(position), 0);
        check(standby == 1'b1, "R8 standby held", int'(standby), 1);
        sel_n = 1'b0;
        idle(5);
        check(standby == 1'b0, "R8 standby cleared", int'(standby), 0);

        // falling increment together with select release (R5, R9)
        @(negedge clk);
        sel_n = 1'b1;
        inc_n = 1'b0;
        idle(6);
        check(position == 0, "R5 edge at deselect", int'(position), 0);
        check(standby == 1'b0, "R9 no standby with increment low", int'(standby), 0);
        inc_n = 1'b1;
        idle(4);
        check(position == 0, "R4 rise while deselected", int'(position), 0);
        sel_n = 1'b0;
        idle(4);

        // resume stepping up (R2)
        repeat (5) step_once(1'b1);
        check(position == 5, "R2 resume", int'(position), 5);
        idle(4);
        check(exp_q.size() == 0, "R7 missing pulses", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule